// File: doc/BRIEF.md
# Pulse-Width Wake-Up Address Decoder

This block listens to a single on-off-keyed "carrier present" line and raises a wake-up pulse when a frame addressed to this node has arrived. Each bit has a fixed period and is sent as one carrier pulse. A long pulse stands for 1 and a short pulse stands for 0, so a short pulse leaves a long gap and a long pulse leaves a short gap. No data clock is sent. Every rising edge of the carrier starts a one-shot timer, counted in system clock cycles. Its length lies between the short and the long pulse width. When the timer runs out, the present line level is taken as the next bit.

A frame has these parts, in transmission order:
- a 0 separator;
- the node address, most significant bit first;
- a second 0 separator;
- a trailer of consecutive 1s.

Legal addresses never hold as many 1s in a row as the trailer, so the full run of trailer 1s can only appear at the end of a complete frame. Because of this, the shift register is compared with the node's static address on every cycle, and no framing counter is needed.

The input is synchronized with two flops. A parameter inverts the polarity, so that gaps in the carrier carry the data instead of carrier bursts. The wake-up output is a single-cycle pulse that fires on the first cycle the match is seen.

Top module: `wake_addr_decoder`

## Requirements
- R1: During and after reset, with the line idle, `wake_pulse` is 0.
- R2: A carrier pulse longer than `ONESHOT_CYC` cycles decodes as 1, and one shorter decodes as 0. The bit is the line level `ONESHOT_CYC` cycles after the synchronized rising edge. Address bits arrive most significant first.
- R3: A frame made of a 0, the address bits, a 0 and `TRIG_LEN` 1s, whose address equals `node_addr`, produces exactly one wake pulse.
- R4: If any single address bit differs from `node_addr`, no wake pulse follows.
- R5: A frame that ends after fewer than `TRIG_LEN` trailer 1s produces no wake pulse.
- R6: If either separator position (the first bit or the bit just before the trailer) holds 1, no wake pulse follows.
- R7: A rising edge that arrives while the one-shot is running restarts it, so the bit is sampled `ONESHOT_CYC` cycles after the latest edge.
- R8: With `INVERT`=1, carrier-off intervals act as the pulses, and the same frames give the same wake results.
- R9: `wake_pulse` is high for one cycle only, and it does not fire again while the completed frame stays in the register.

The one-shot has two states:
- OSH_IDLE moves to OSH_RUN on a rising edge.
- OSH_RUN restarts on an edge, or moves back to OSH_IDLE on expiry, which emits the sample strobe.

The match guard has two states:
- MT_ARMED moves to MT_FIRED when a match appears, and fires the pulse.
- MT_FIRED moves back to MT_ARMED once the match clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_in | input | 1 | Asynchronous carrier-present line |
| node_addr | input | ADDR_W | Static address of this node |
| wake_pulse | output | 1 | One-cycle wake-up strobe |

## Verification
The bench builds the decoder with `ONESHOT_CYC`=6, a 16-cycle bit period, 3-cycle short pulses and 10-cycle long pulses. This puts the sampling instant well inside both pulse classes. The bench runs a second instance with `INVERT`=1 and feeds it the complemented line, so both polarities see every frame. A glitch pulse (1 cycle high, 4 low, 5 high) decodes to different values depending on whether a second edge restarts the timer. The bench also sends frames with a short trailer and with a separator flipped to 1. Each frame is compared against a count of wake pulses.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
    typedef enum logic {
        OSH_IDLE = 1'b0,
        OSH_RUN  = 1'b1
    } osh_state_e;

    typedef enum logic {
        MT_ARMED = 1'b0,
        MT_FIRED = 1'b1
    } mt_state_e;
endpackage

// File: rtl/wkd_sync.sv
module wkd_sync #(
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_o,
    output logic rise_o
);
    logic meta_q, sync_q, lvl_q;
    logic lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INVERT;
            sync_q <= INVERT;
            lvl_q  <= 1'b0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            lvl_q  <= lvl;
        end
    end

    assign lvl     = sync_q ^ INVERT;
    assign level_o = lvl;
    assign rise_o  = lvl & ~lvl_q;
endmodule

// File: rtl/wkd_oneshot.sv
module wkd_oneshot
    import wkd_pkg::*;
#(
    parameter int LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic sample_o,
    output logic busy_o
);
    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

    osh_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OSH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OSH_IDLE: if (rise_i) state_d = OSH_RUN;
            OSH_RUN: begin
                if (rise_i)           state_d = OSH_RUN;
                else if (cnt_q == '0) state_d = OSH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (rise_i)                           cnt_q <= LOAD;
        else if (state_q == OSH_RUN && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        sample_o = (state_q == OSH_RUN) && !rise_i && (cnt_q == '0);
        busy_o   = (state_q == OSH_RUN);
    end
endmodule

// File: rtl/wkd_frame_match.sv
module wkd_frame_match
    import wkd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int TRIG_LEN = 4,
    localparam int FRAME_W = ADDR_W + TRIG_LEN + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              level_i,
    input  logic [ADDR_W-1:0] node_addr_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic              wake_o
);
    localparam int ADDR_LO = TRIG_LEN + 1;
    localparam int ADDR_HI = TRIG_LEN + ADDR_W;

    logic [FRAME_W-1:0] frame_q;
    logic trig_ok, addr_ok, sep_ok, match;
    mt_state_e state_q, state_d;
    logic wake_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        frame_q <= '0;
        else if (sample_i) frame_q <= {frame_q[FRAME_W-2:0], level_i};
    end

    always_comb begin
        trig_ok = &frame_q[TRIG_LEN-1:0];
        addr_ok = &(~(frame_q[ADDR_HI:ADDR_LO] ^ node_addr_i));
        sep_ok  = !frame_q[TRIG_LEN] && !frame_q[FRAME_W-1];
        match   = trig_ok && addr_ok && sep_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MT_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MT_ARMED: if (match)  state_d = MT_FIRED;
            MT_FIRED: if (!match) state_d = MT_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= (state_q == MT_ARMED) && match;
    end

    assign wake_o  = wake_q;
    assign frame_o = frame_q;
endmodule

// File: rtl/wake_addr_decoder.sv
module wake_addr_decoder #(
    parameter int ADDR_W      = 8,
    parameter int TRIG_LEN    = 4,
    parameter int ONESHOT_CYC = 6,
    parameter bit INVERT      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier_in,
    input  logic [ADDR_W-1:0] node_addr,
    output logic              wake_pulse
);
    localparam int FRAME_W = ADDR_W + TRIG_LEN + 2;

    logic level, rise, sample, busy;
    logic [FRAME_W-1:0] frame_q;

    wkd_sync #(.INVERT(INVERT)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(carrier_in),
        .level_o(level), .rise_o(rise)
    );

    wkd_oneshot #(.LEN(ONESHOT_CYC)) u_oneshot (
        .clk(clk), .rst_n(rst_n), .rise_i(rise),
        .sample_o(sample), .busy_o(busy)
    );

    wkd_frame_match #(.ADDR_W(ADDR_W), .TRIG_LEN(TRIG_LEN)) u_match (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .level_i(level),
        .node_addr_i(node_addr), .frame_o(frame_q), .wake_o(wake_pulse)
    );
endmodule

// File: rtl/wkd_checker.sv
module wkd_checker #(
    parameter int ADDR_W   = 8,
    parameter int TRIG_LEN = 4,
    localparam int FRAME_W = ADDR_W + TRIG_LEN + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wake_pulse,
    input logic [ADDR_W-1:0]  node_addr,
    input logic [FRAME_W-1:0] frame_q,
    input logic               sample,
    input logic               rise,
    input logic               busy
);
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R9
    AST_WAKE_NEEDS_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(&frame_q[TRIG_LEN-1:0])); // R5
    AST_WAKE_ADDR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(frame_q[TRIG_LEN+ADDR_W:TRIG_LEN+1]) == $past(node_addr))); // R4
    AST_WAKE_SEPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(frame_q[TRIG_LEN]) == 1'b0 && $past(frame_q[FRAME_W-1]) == 1'b0)); // R6
    AST_SHIFT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(frame_q)); // R2
    AST_EDGE_STARTS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> busy); // R7
    AST_SAMPLE_ENDS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !busy); // R7
endmodule

bind wake_addr_decoder wkd_checker #(.ADDR_W(ADDR_W), .TRIG_LEN(TRIG_LEN)) u_wkd_checker (
    .clk(clk), .rst_n(rst_n), .wake_pulse(wake_pulse), .node_addr(node_addr),
    .frame_q(frame_q), .sample(sample), .rise(rise), .busy(busy)
);

// File: tb/test_wake_addr_decoder.sv
module test_wake_addr_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int TRIG_LEN = 4;
    localparam int ONESHOT = 6;
    localparam int BIT_PER = 16;
    localparam int SHORT_HI = 3;
    localparam int LONG_HI = 10;
    localparam int NVEC = 6;
    // {address sent, node address, expected wake count}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h5A, 8'h5A, 1'b1},
        {8'h5A, 8'h5B, 1'b0},
        {8'h00, 8'h00, 1'b1},
        {8'h77, 8'h77, 1'b1},
        {8'h92, 8'h12, 1'b0},
        {8'hB6, 8'hB6, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carrier = 1'b0;
    logic [ADDR_W-1:0] node = '0;
    logic wake_a, wake_b;
    int pulses_a = 0, pulses_b = 0;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_addr_decoder #(.ADDR_W(ADDR_W), .TRIG_LEN(TRIG_LEN), .ONESHOT_CYC(ONESHOT), .INVERT(1'b0))
    i_wake_addr_decoder (.clk(clk), .rst_n(rst_n), .carrier_in(carrier), .node_addr(node), .wake_pulse(wake_a));

    wake_addr_decoder #(.ADDR_W(ADDR_W), .TRIG_LEN(TRIG_LEN), .ONESHOT_CYC(ONESHOT), .INVERT(1'b1))
    i_wake_addr_decoder_inv (.clk(clk), .rst_n(rst_n), .carrier_in(~carrier), .node_addr(node), .wake_pulse(wake_b));

    always @(negedge clk) begin
        if (wake_a) pulses_a++;
        if (wake_b) pulses_b++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic send_bit(input logic v);
        int hi = v ? LONG_HI : SHORT_HI;
        carrier = 1'b1;
        repeat (hi) @(negedge clk);
        carrier = 1'b0;
        repeat (BIT_PER - hi) @(negedge clk);
    endtask

    // short high, pause, then a second edge: a 0 only if the timer restarts
    task automatic send_glitch_zero();
        carrier = 1'b1; repeat (1) @(negedge clk);
        carrier = 1'b0; repeat (4) @(negedge clk);
        carrier = 1'b1; repeat (5) @(negedge clk);
        carrier = 1'b0; repeat (6) @(negedge clk);
    endtask

    task automatic send_frame(input logic lead, input logic [ADDR_W-1:0] a,
                              input logic sep, input int ntrig, input bit glitch_lsb);
        send_bit(lead);
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            if (i == 0 && glitch_lsb && !a[0]) send_glitch_zero();
            else send_bit(a[i]);
        end
        send_bit(sep);
        for (int i = 0; i < ntrig; i++) send_bit(1'b1);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int pa, pb;
        repeat (4) @(negedge clk);
        check("R1 reset wake", int'(wake_a), 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check("R1 idle pulses", pulses_a, 0);
        check("R1 idle pulses inverted", pulses_b, 0);

        for (int k = 0; k < NVEC; k++) begin
            node = VEC[k][8:1];
            pa = pulses_a; pb = pulses_b;
            send_frame(1'b0, VEC[k][16:9], 1'b0, TRIG_LEN, 1'b0);
            check("R2 R3 R4 frame wake count", pulses_a - pa, int'(VEC[k][0]));
            check("R8 inverted wake count", pulses_b - pb, int'(VEC[k][0]));
        end

        node = 8'h5A;
        pa = pulses_a;
        send_frame(1'b0, 8'h5A, 1'b0, TRIG_LEN, 1'b0);
        repeat (60) @(negedge clk);
        check("R9 single pulse, no repeat", pulses_a - pa, 1);

        pa = pulses_a;
        send_frame(1'b0, 8'h5A, 1'b0, TRIG_LEN - 1, 1'b0);
        check("R5 short trailer", pulses_a - pa, 0);

        pa = pulses_a;
        send_frame(1'b0, 8'h5A, 1'b1, TRIG_LEN, 1'b0);
        check("R6 inner separator set", pulses_a - pa, 0);

        pa = pulses_a;
        send_frame(1'b1, 8'h5A, 1'b0, TRIG_LEN, 1'b0);
        check("R6 leading separator set", pulses_a - pa, 0);

        pa = pulses_a; pb = pulses_b;
        send_frame(1'b0, 8'h5A, 1'b0, TRIG_LEN, 1'b1);
        check("R7 retrigger decodes zero", pulses_a - pa, 1);
        check("R8 R7 inverted retrigger", pulses_b - pb, 1);

        node = 8'h5B;
        pa = pulses_a;
        send_frame(1'b0, 8'h5B, 1'b0, TRIG_LEN, 1'b0);
        check("R2 long pulse on last address bit", pulses_a - pa, 1);

        finish_run();
    end
endmodule